// File: doc/BRIEF.md
# Scan Chain Serializer and Router

This block turns parallel words written by a processor into a serial bit stream and steers that stream onto one of several scan chains. Software picks a chain with a 3-bit index, sets how many bits of each word are to leave (1 to 32), and then writes the word. The block shifts the word out LSB first. Each bit gets one serial clock pulse: data changes as the clock falls and is stable when it rises.

Four of the chains are raw I/O configuration chains. They carry only a data line and a clock, with no JTAG state machine behind them. A fifth chain, at index 7, leads to a fabric JTAG TAP controller. That link is off after reset, and while it is off the external JTAG pins reach the TAP unchanged. Software sets an enable bit to take the TAP over. In that case the block also drives a mode-select line, which it can raise on the final bit of a word so that the TAP can leave its shift state. Indices 4, 5 and 6 are not wired to any chain.

An external configuration mode input overrides the processor. While it is high, the four I/O chains follow a set of external clock and data pins. Any shift in progress stops at once, and an abort status bit records the loss.

Top module: `scan_router`

## Requirements
- R1: Registers at `wr_addr`: 0 is control (chain index in bits 2:0, TAP link enable in bit 4, mode-select-on-last-bit in bit 5); 1 is length (bits 4:0 hold bit count minus one); 2 is data (a write starts a shift); 3 is clear (any write clears the three sticky flags). After reset: index 0, link off, mode-select-on-last off, length 32.
- R2: A shift drives the selected chain with one clock pulse per bit, LSB first. Each clock phase lasts HALF cycles. Data changes only as the clock falls. `busy` rises on the clock edge that takes the data write and stays high for exactly 2*N*HALF cycles.
- R3: Only the selected chain is clocked. The clock and data lines of every other chain stay 0, and with no shift running and no override, all block-driven clocks are 0.
- R4: With the link off (the reset state), `tap_tck`, `tap_tdi` and `tap_tms` equal `ext_tck`, `ext_tdi` and `ext_tms`. With the link on, the block drives them. `tap_tms` is 1 only during the final bit of a chain 7 shift, and only when mode-select-on-last is set.
- R5: A data write whose index is 4, 5 or 6, or is 7 while the link is off, produces no clock pulse on any chain, leaves `busy` low and sets the sticky `err_sel`.
- R6: Any write made while `busy` is high is ignored, including control, length and clear writes. A data write while `cfg_io_mode` is high is also ignored. Both set the sticky `err_rej`.
- R7: While `cfg_io_mode` is high, `io_tck` and `io_tdi` equal `ext_io_clk` and `ext_io_dat` in the same cycle. If a shift is running, it ends on the next edge: `busy` goes low, the TAP clock goes low, and the sticky `aborted` is set.
- R8: The bit count N can be any value from 1 to 32, and exactly N bits leave per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| cfg_io_mode | input | 1 | External configuration override |
| ext_io_clk | input | 4 | External clocks for the I/O chains under override |
| ext_io_dat | input | 4 | External data for the I/O chains under override |
| ext_tck | input | 1 | External JTAG clock pin |
| ext_tdi | input | 1 | External JTAG data pin |
| ext_tms | input | 1 | External JTAG mode-select pin |
| io_tck | output | 4 | Clocks of I/O chains 0..3 |
| io_tdi | output | 4 | Data of I/O chains 0..3 |
| tap_tck | output | 1 | Clock to the TAP controller |
| tap_tdi | output | 1 | Data to the TAP controller |
| tap_tms | output | 1 | Mode-select to the TAP controller |
| busy | output | 1 | A shift is running |
| err_sel | output | 1 | Sticky: data write to a dead or unlinked chain |
| err_rej | output | 1 | Sticky: write ignored |
| aborted | output | 1 | Sticky: shift cut off by override |

## Verification
The override and a running shift can land in the same cycle. The bench provokes this by raising `cfg_io_mode` partway through a 16-bit shift on chain 2. In that same cycle it checks that the I/O lines already follow the external pins. One edge later it checks that `busy` is low, the TAP clock is low and `aborted` is set, and it drops the expected bits that were never sent. A second collision, a register write that lands during a shift, is checked at the ports: the word that was already running must complete bit for bit, and the ignored chain change must not steer the next word.

// File: rtl/scan_router_pkg.sv
package scan_router_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LEN  = 2'd1,
    REG_DATA = 2'd2,
    REG_CLR  = 2'd3
  } reg_addr_e;

  localparam int CTRL_LINK_BIT = 4;
  localparam int CTRL_TMS_BIT  = 5;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
  import scan_router_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 3,
  parameter int IO_CHAINS = 4,
  parameter int TAP_SEL   = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      busy,
  input  logic                      ovr,
  input  logic                      abort_evt,
  output logic [SEL_W-1:0]          sel,
  output logic                      link_en,
  output logic                      tms_last,
  output logic [$clog2(DATA_W)-1:0] len_m1,
  output logic                      start,
  output logic                      err_sel,
  output logic                      err_rej,
  output logic                      aborted
);
  localparam int LW = $clog2(DATA_W);

  logic wr_ok, data_wr, live, bad_wr, rej_wr, clr_wr;

  assign live    = (sel < SEL_W'(IO_CHAINS)) || ((sel == SEL_W'(TAP_SEL)) && link_en);
  assign wr_ok   = wr_en && !busy;
  assign data_wr = wr_ok && (wr_addr == REG_DATA) && !ovr;
  assign start   = data_wr && live;
  assign bad_wr  = data_wr && !live;
  assign rej_wr  = wr_en && (busy || (ovr && (wr_addr == REG_DATA)));
  assign clr_wr  = wr_ok && (wr_addr == REG_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= '0;
      link_en  <= 1'b0;
      tms_last <= 1'b0;
      len_m1   <= '1;
      err_sel  <= 1'b0;
      err_rej  <= 1'b0;
      aborted  <= 1'b0;
    end else begin
      if (wr_ok && (wr_addr == REG_CTRL)) begin
        sel      <= wr_data[SEL_W-1:0];
        link_en  <= wr_data[CTRL_LINK_BIT];
        tms_last <= wr_data[CTRL_TMS_BIT];
      end
      if (wr_ok && (wr_addr == REG_LEN))
        len_m1 <= wr_data[LW-1:0];
      err_sel <= bad_wr    | (err_sel & ~clr_wr);
      err_rej <= rej_wr    | (err_rej & ~clr_wr);
      aborted <= abort_evt | (aborted & ~clr_wr);
    end
  end
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter #(
  parameter int DATA_W = 32,
  parameter int HALF   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [DATA_W-1:0]         din,
  input  logic [$clog2(DATA_W)-1:0] len_m1,
  input  logic                      abort,
  output logic                      busy,
  output logic                      sck,
  output logic                      sdo,
  output logic                      last_bit,
  output logic                      abort_evt
);
  localparam int LW = $clog2(DATA_W);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DATA_W-1:0] shreg;
  logic [LW-1:0]     left;
  logic [HW-1:0]     hcnt;
  logic              half_done;

  assign half_done = (hcnt == HW'(HALF - 1));
  assign last_bit  = busy && (left == '0);
  assign abort_evt = busy && abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sck   <= 1'b0;
      sdo   <= 1'b0;
      shreg <= '0;
      left  <= '0;
      hcnt  <= '0;
    end else if (abort_evt) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      sdo  <= 1'b0;
      hcnt <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      sck   <= 1'b0;
      sdo   <= din[0];
      shreg <= din >> 1;
      left  <= len_m1;
      hcnt  <= '0;
    end else if (busy) begin
      if (half_done) begin
        hcnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
        end else begin
          sck <= 1'b0;
          if (left == '0) begin
            busy <= 1'b0;
            sdo  <= 1'b0;
          end else begin
            sdo   <= shreg[0];
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_route.sv
module scan_route #(
  parameter int SEL_W     = 3,
  parameter int IO_CHAINS = 4,
  parameter int TAP_SEL   = 7
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic                 link_en,
  input  logic                 busy,
  input  logic                 sck,
  input  logic                 sdo,
  input  logic                 tms_drv,
  input  logic                 ovr,
  input  logic [IO_CHAINS-1:0] ext_io_clk,
  input  logic [IO_CHAINS-1:0] ext_io_dat,
  input  logic                 ext_tck,
  input  logic                 ext_tdi,
  input  logic                 ext_tms,
  output logic [IO_CHAINS-1:0] io_tck,
  output logic [IO_CHAINS-1:0] io_tdi,
  output logic                 tap_tck,
  output logic                 tap_tdi,
  output logic                 tap_tms
);
  logic tap_hit;

  for (genvar i = 0; i < IO_CHAINS; i++) begin : g_io
    logic hit;
    assign hit       = busy && (sel == SEL_W'(i));
    assign io_tck[i] = ovr ? ext_io_clk[i] : (hit & sck);
    assign io_tdi[i] = ovr ? ext_io_dat[i] : (hit & sdo);
  end

  assign tap_hit = busy && (sel == SEL_W'(TAP_SEL));
  assign tap_tck = link_en ? (tap_hit & sck)     : ext_tck;
  assign tap_tdi = link_en ? (tap_hit & sdo)     : ext_tdi;
  assign tap_tms = link_en ? (tap_hit & tms_drv) : ext_tms;
endmodule

// File: rtl/scan_router.sv
module scan_router #(
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 3,
  parameter int IO_CHAINS = 4,
  parameter int TAP_SEL   = 7,
  parameter int HALF      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 cfg_io_mode,
  input  logic [IO_CHAINS-1:0] ext_io_clk,
  input  logic [IO_CHAINS-1:0] ext_io_dat,
  input  logic                 ext_tck,
  input  logic                 ext_tdi,
  input  logic                 ext_tms,
  output logic [IO_CHAINS-1:0] io_tck,
  output logic [IO_CHAINS-1:0] io_tdi,
  output logic                 tap_tck,
  output logic                 tap_tdi,
  output logic                 tap_tms,
  output logic                 busy,
  output logic                 err_sel,
  output logic                 err_rej,
  output logic                 aborted
);
  localparam int LW = $clog2(DATA_W);

  logic [SEL_W-1:0] sel;
  logic             link_en, tms_last, start, sck, sdo, last_bit, abort_evt;
  logic [LW-1:0]    len_m1;

  scan_regs #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .IO_CHAINS(IO_CHAINS), .TAP_SEL(TAP_SEL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .ovr(cfg_io_mode), .abort_evt(abort_evt),
    .sel(sel), .link_en(link_en), .tms_last(tms_last), .len_m1(len_m1),
    .start(start), .err_sel(err_sel), .err_rej(err_rej), .aborted(aborted)
  );

  scan_shifter #(.DATA_W(DATA_W), .HALF(HALF)) u_shift (
    .clk(clk), .rst(rst), .start(start), .din(wr_data), .len_m1(len_m1),
    .abort(cfg_io_mode), .busy(busy), .sck(sck), .sdo(sdo),
    .last_bit(last_bit), .abort_evt(abort_evt)
  );

  scan_route #(.SEL_W(SEL_W), .IO_CHAINS(IO_CHAINS), .TAP_SEL(TAP_SEL)) u_route (
    .sel(sel), .link_en(link_en), .busy(busy), .sck(sck), .sdo(sdo),
    .tms_drv(tms_last & last_bit), .ovr(cfg_io_mode),
    .ext_io_clk(ext_io_clk), .ext_io_dat(ext_io_dat),
    .ext_tck(ext_tck), .ext_tdi(ext_tdi), .ext_tms(ext_tms),
    .io_tck(io_tck), .io_tdi(io_tdi),
    .tap_tck(tap_tck), .tap_tdi(tap_tdi), .tap_tms(tap_tms)
  );
endmodule

// File: rtl/scan_router_chk.sv
module scan_router_chk #(
  parameter int IO_CHAINS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [1:0]           wr_addr,
  input logic                 cfg_io_mode,
  input logic                 link_en,
  input logic                 busy,
  input logic [IO_CHAINS-1:0] io_tck,
  input logic [IO_CHAINS-1:0] io_tdi,
  input logic                 tap_tck,
  input logic                 tap_tms,
  input logic                 ext_tck,
  input logic                 ext_tms,
  input logic                 err_sel,
  input logic                 err_rej,
  input logic                 aborted
);
  // R2
  data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_io_mode && $past(!cfg_io_mode) && busy && $past(busy) && !$stable(io_tdi))
      |-> (io_tck == '0 && $past(io_tck) != '0));

  // R3
  one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_io_mode |-> $onehot0({io_tck, link_en & tap_tck}));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cfg_io_mode) |-> (io_tck == '0 && (!link_en || !tap_tck)));

  // R4
  tap_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !link_en |-> (tap_tck == ext_tck && tap_tms == ext_tms));

  // R5
  err_sel_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(err_sel) && !$past(wr_en && wr_addr == 2'd3 && !busy)) |-> err_sel);

  // R6
  busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> err_rej);

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_io_mode) |=> (!busy && aborted && (!link_en || !tap_tck)));
endmodule

bind scan_router scan_router_chk #(.IO_CHAINS(IO_CHAINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg_io_mode(cfg_io_mode), .link_en(link_en), .busy(busy),
  .io_tck(io_tck), .io_tdi(io_tdi), .tap_tck(tap_tck), .tap_tms(tap_tms),
  .ext_tck(ext_tck), .ext_tms(ext_tms),
  .err_sel(err_sel), .err_rej(err_rej), .aborted(aborted)
);

// File: tb/scan_router_test.sv
module scan_router_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cfg_io_mode = 1'b0;
  logic [3:0]  ext_io_clk = '0, ext_io_dat = '0;
  logic        ext_tck = 1'b0, ext_tdi = 1'b0, ext_tms = 1'b0;
  logic [3:0]  io_tck, io_tdi;
  logic        tap_tck, tap_tdi, tap_tms, busy, err_sel, err_rej, aborted;

  always #(CLK_P/2) clk = ~clk;

  scan_router #(.HALF(HALF)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_io_mode(cfg_io_mode), .ext_io_clk(ext_io_clk), .ext_io_dat(ext_io_dat),
    .ext_tck(ext_tck), .ext_tdi(ext_tdi), .ext_tms(ext_tms),
    .io_tck(io_tck), .io_tdi(io_tdi), .tap_tck(tap_tck), .tap_tdi(tap_tdi),
    .tap_tms(tap_tms), .busy(busy), .err_sel(err_sel), .err_rej(err_rej),
    .aborted(aborted)
  );

  typedef struct { int chain; logic dat; logic tms; } exp_t;
  exp_t exp_q[$];
  int   checks = 0, failures = 0;
  bit   mon_off = 1'b0;
  bit   done = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(int chain, bit link, bit tms);
    return 32'(chain) | (32'(link) << 4) | (32'(tms) << 5);
  endfunction

  task automatic push_word(int chain, int n, logic [31:0] d, bit tms);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.chain = chain; e.dat = d[i]; e.tms = tms && (i == n - 1);
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_word(string req, int chain, int n, logic [31:0] d, bit tms);
    int cyc;
    push_word(chain, n, d, tms);
    reg_write(2'd2, d);
    wait_idle(cyc);
    check(cyc == 2*n*HALF, req, "busy cycles", 32'(cyc), 32'(2*n*HALF));
    check(exp_q.size() == 0, req, "bits left unsent", 32'(exp_q.size()), 0);
  endtask

  // monitor: pops one expected bit on every clock rise of any chain
  logic [4:0] prev_clk = '0;
  always @(negedge clk) begin
    logic [4:0] cur;
    cur = {tap_tck, io_tck};
    if (!mon_off && !rst) begin
      for (int c = 0; c < 5; c++) begin
        if (cur[c] && !prev_clk[c]) begin
          int ch;
          logic dv;
          ch = (c == 4) ? 7 : c;
          dv = (c == 4) ? tap_tdi : io_tdi[c];
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected clock pulse on chain", 32'(ch), 32'hFFFF);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.chain == ch, "R3", "pulse chain", 32'(ch), 32'(e.chain));
            check(dv == e.dat, "R2", "serial bit", 32'(dv), 32'(e.dat));
            if (c == 4)
              check(tap_tms == e.tms, "R4", "tap_tms at rise", 32'(tap_tms), 32'(e.tms));
          end
        end
      end
    end
    prev_clk = cur;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    int cyc;
    ext_tms = 1'b1; ext_tdi = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R4 pass-through with link off
    check(!busy && !err_sel && !err_rej && !aborted, "R1", "flags after reset",
          {busy, err_sel, err_rej, aborted}, 0);
    check(io_tck == 0 && io_tdi == 0, "R3", "io lines idle", {io_tck, io_tdi}, 0);
    check(tap_tms == 1'b1 && tap_tdi == 1'b1, "R4", "tap follows pins",
          {tap_tms, tap_tdi}, 2'b11);
    ext_tms = 1'b0; ext_tdi = 1'b0;

    // R1 default length 32 on chain 0
    run_word("R1", 0, 32, 32'hC3A5_0F96, 1'b0);
    // R2 byte on chain 0
    reg_write(2'd1, 32'd7);
    run_word("R2", 0, 8, 32'h0000_00A5, 1'b0);
    // R8 single bit on chain 1, then full word on chain 3
    reg_write(2'd0, ctrl_word(1, 0, 0));
    reg_write(2'd1, 32'd0);
    run_word("R8", 1, 1, 32'h1, 1'b0);
    reg_write(2'd0, ctrl_word(3, 0, 0));
    reg_write(2'd1, 32'd31);
    run_word("R8", 3, 32, 32'h8000_0001, 1'b0);

    // R5 chain 7 with link off
    reg_write(2'd0, ctrl_word(7, 0, 0));
    reg_write(2'd2, 32'hFFFF_FFFF);
    check(!busy && err_sel, "R5", "unlinked chain 7 rejected", {busy, err_sel}, 2'b01);
    repeat (8) @(negedge clk);
    // R1 clear
    reg_write(2'd3, 32'd0);
    check(!err_sel, "R1", "clear drops err_sel", err_sel, 0);

    // R5 dead index 5
    reg_write(2'd0, ctrl_word(5, 1, 0));
    reg_write(2'd2, 32'hFFFF_FFFF);
    check(!busy && err_sel, "R5", "index 5 rejected", {busy, err_sel}, 2'b01);
    repeat (8) @(negedge clk);
    reg_write(2'd3, 32'd0);

    // R4 chain 7 linked, mode-select on last bit
    reg_write(2'd0, ctrl_word(7, 1, 1));
    reg_write(2'd1, 32'd4);
    ext_tms = 1'b1;
    @(negedge clk);
    check(tap_tms == 1'b0, "R4", "linked tap ignores pin", tap_tms, 0);
    run_word("R4", 7, 5, 32'h0000_0016, 1'b1);
    reg_write(2'd0, ctrl_word(7, 1, 0));
    run_word("R4", 7, 5, 32'h0000_0009, 1'b0);
    ext_tms = 1'b0;

    // R6 writes during a shift are ignored
    reg_write(2'd0, ctrl_word(0, 0, 0));
    reg_write(2'd1, 32'd11);
    push_word(0, 12, 32'h0000_0B6D, 1'b0);
    reg_write(2'd2, 32'h0000_0B6D);
    reg_write(2'd0, ctrl_word(3, 0, 0));
    reg_write(2'd1, 32'd2);
    check(err_rej, "R6", "write while busy flagged", err_rej, 1);
    wait_idle(cyc);
    check(exp_q.size() == 0, "R6", "word unharmed", 32'(exp_q.size()), 0);
    run_word("R6", 0, 12, 32'h0000_0A5A, 1'b0);
    reg_write(2'd3, 32'd0);

    // R7 override in the middle of a shift
    reg_write(2'd0, ctrl_word(2, 0, 0));
    reg_write(2'd1, 32'd15);
    push_word(2, 16, 32'h0000_F0F0, 1'b0);
    reg_write(2'd2, 32'h0000_F0F0);
    repeat (7) @(negedge clk);
    mon_off = 1'b1;
    cfg_io_mode = 1'b1; ext_io_clk = 4'b0101; ext_io_dat = 4'b1010;
    #1;
    check(io_tck == 4'b0101 && io_tdi == 4'b1010, "R7", "override same cycle",
          {io_tck, io_tdi}, {4'b0101, 4'b1010});
    @(negedge clk);
    check(!busy && aborted, "R7", "shift aborted", {busy, aborted}, 2'b01);
    exp_q.delete();
    reg_write(2'd2, 32'h1);
    check(!busy && err_rej, "R6", "data write under override", {busy, err_rej}, 2'b01);
    cfg_io_mode = 1'b0; ext_io_clk = '0; ext_io_dat = '0;
    @(negedge clk);
    mon_off = 1'b0;
    reg_write(2'd3, 32'd0);
    check(!aborted && !err_rej && !err_sel, "R1", "clear all flags",
          {aborted, err_rej, err_sel}, 0);
    run_word("R7", 2, 16, 32'h0000_3C3C, 1'b0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule